// File: doc/BRIEF.md
# Key-Protected Clock Control Register

This block holds the clock and power settings of a chip: a divide code for the system clock, a run bit for the peripheral prescaler, the choice of CPU clock source, and the enables of a high-speed and a low-speed oscillator. A separate guard register, on the same byte-wide register bus, decides whether the settings may change. Writing the unlock key 0x96 into the guard opens the settings for any number of writes. Writing any other byte into the guard closes them again. While the settings are closed, writes to them are dropped without notice.

The block only produces the control values. The clock switch and the oscillator circuits that use them are outside it. It also refuses any write that would stop the oscillator driving the CPU clock. It does not let the CPU clock move to an oscillator that would be off after the write.

Top module: `clkctl_keyreg`

## Requirements
- R1: After a synchronous reset the divide code is 0, the prescaler run bit, the clock switch and both oscillator enables are 1, the guard register reads 0x00 and the block is locked.
- R2: A bus write of exactly 0x96 to the guard address (1) unlocks the block from the next cycle. A control write (address 0) made while unlocked updates the outputs on the clock edge that takes it.
- R3: A bus write of any value other than 0x96 to the guard address locks the block again. Later control writes are then ignored.
- R4: A control write made while locked changes no output and no read value.
- R5: The unlock stays in force across any number of control writes until the guard register is rewritten.
- R6: Control byte layout: bits 7:6 divide code, bit 5 prescaler run, bit 2 clock switch (1 = high-speed, 0 = low-speed), bit 1 high-speed enable, bit 0 low-speed enable. Bits 4:3 always read 0 whatever was written.
- R7: The divide factor output is one-hot: code 0 gives 1 (bit 0), code 1 gives 2, code 2 gives 4, code 3 gives 8.
- R8: A write that clears the enable of the oscillator selected before the write leaves that enable at 1. The other bits of the write still apply.
- R9: A write that selects an oscillator whose enable is 0 after the write leaves the clock switch unchanged. The selected oscillator's enable is therefore always 1.
- R10: Reading the control address returns the control byte and reading the guard address returns the last byte written to the guard. Any other address reads 0x00. A write to any other address changes nothing.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous active-high reset |
| bus_addr | input | ADDR_W (4) | Register address |
| bus_we | input | 1 | Write strobe |
| bus_wdata | input | 8 | Write data |
| bus_rdata | output | 8 | Read data for bus_addr (combinational) |
| sys_div_code | output | 2 | System clock divide code |
| sys_div_factor | output | 4 | One-hot divide factor (1, 2, 4, 8) |
| presc_run | output | 1 | Prescaler run |
| cpu_clk_fast | output | 1 | CPU clock source, 1 = high-speed oscillator |
| hs_osc_en | output | 1 | High-speed oscillator enable |
| ls_osc_en | output | 1 | Low-speed oscillator enable |
| ctrl_unlocked | output | 1 | Guard holds the key |

## Verification
The bench probes key values one bit away from 0x96. A guard that compared only some bits would unlock on them. It relocks after several accepted writes, and a one-shot unlock would drop the second control write. It writes 1s into the reserved bits, tries to clear the enable of the running oscillator, and tries to switch to an oscillator that is off or being turned off in the same write. A design that got these wrong would show reserved 1s on read or leave the CPU on a stopped clock. Random traffic mixes guard, control and stray-address writes so that lock state and field updates are checked together.

// File: rtl/clkctl_keyreg_pkg.sv
package clkctl_keyreg_pkg;

    localparam int BYTE_W   = 8;
    localparam int DIV_W    = 2;
    localparam int FACTOR_W = 1 << DIV_W;

    // bit positions inside the control byte
    localparam int POS_DIV_LO = 6;
    localparam int POS_RUN    = 5;
    localparam int POS_SW     = 2;
    localparam int POS_HS     = 1;
    localparam int POS_LS     = 0;

    typedef struct packed {
        logic [DIV_W-1:0] div;
        logic             run;
        logic             fast;
        logic             hs;
        logic             ls;
    } ctrl_t;

    localparam ctrl_t CTRL_RESET = '{div: '0, run: 1'b1, fast: 1'b1, hs: 1'b1, ls: 1'b1};

    function automatic logic [BYTE_W-1:0] ctrl_to_byte(input ctrl_t c);
        logic [BYTE_W-1:0] b;
        b = '0;
        b[POS_DIV_LO +: DIV_W] = c.div;
        b[POS_RUN]             = c.run;
        b[POS_SW]              = c.fast;
        b[POS_HS]              = c.hs;
        b[POS_LS]              = c.ls;
        return b;
    endfunction

    // apply a bus byte while keeping the CPU clock on a running oscillator
    function automatic ctrl_t guarded_update(input ctrl_t cur, input logic [BYTE_W-1:0] w);
        ctrl_t n;
        logic  target_on;
        n.div  = w[POS_DIV_LO +: DIV_W];
        n.run  = w[POS_RUN];
        n.hs   = cur.fast ? 1'b1 : w[POS_HS];
        n.ls   = cur.fast ? w[POS_LS] : 1'b1;
        target_on = w[POS_SW] ? n.hs : n.ls;
        n.fast = target_on ? w[POS_SW] : cur.fast;
        return n;
    endfunction

    function automatic logic [FACTOR_W-1:0] div_factor(input logic [DIV_W-1:0] code);
        logic [FACTOR_W-1:0] f;
        f = '0;
        f[code] = 1'b1;
        return f;
    endfunction

endpackage

// File: rtl/clkctl_keyreg_dec.sv
module clkctl_keyreg_dec #(
    parameter int                ADDR_W    = 4,
    parameter logic [ADDR_W-1:0] CTRL_ADDR = '0,
    parameter logic [ADDR_W-1:0] KEY_ADDR  = 1
) (
    input  logic [ADDR_W-1:0] addr,
    input  logic              we,
    output logic              ctrl_sel,
    output logic              key_sel,
    output logic              ctrl_we,
    output logic              key_we
);
    always_comb begin
        ctrl_sel = (addr == CTRL_ADDR);
        key_sel  = (addr == KEY_ADDR);
        ctrl_we  = we && ctrl_sel;
        key_we   = we && key_sel;
    end
endmodule

// File: rtl/clkctl_keyreg_lock.sv
module clkctl_keyreg_lock
    import clkctl_keyreg_pkg::*;
#(
    parameter logic [BYTE_W-1:0] UNLOCK_KEY = 8'h96
) (
    input  logic              clk,
    input  logic              rst,
    input  logic              key_we,
    input  logic [BYTE_W-1:0] wdata,
    output logic [BYTE_W-1:0] key_q,
    output logic              unlocked
);
    always_ff @(posedge clk) begin
        if (rst) begin
            key_q <= '0;
        end else if (key_we) begin
            key_q <= wdata;
        end
    end

    assign unlocked = (key_q == UNLOCK_KEY);
endmodule

// File: rtl/clkctl_keyreg_ctrl.sv
module clkctl_keyreg_ctrl
    import clkctl_keyreg_pkg::*;
(
    input  logic              clk,
    input  logic              rst,
    input  logic              ctrl_we,
    input  logic              unlocked,
    input  logic [BYTE_W-1:0] wdata,
    output ctrl_t             ctrl_q
);
    ctrl_t ctrl_d;

    always_comb begin
        ctrl_d = ctrl_q;
        if (ctrl_we && unlocked) begin
            ctrl_d = guarded_update(ctrl_q, wdata);
        end
    end

    always_ff @(posedge clk) begin
        if (rst) begin
            ctrl_q <= CTRL_RESET;
        end else begin
            ctrl_q <= ctrl_d;
        end
    end
endmodule

// File: rtl/clkctl_keyreg.sv
module clkctl_keyreg
    import clkctl_keyreg_pkg::*;
#(
    parameter int                ADDR_W     = 4,
    parameter logic [ADDR_W-1:0] CTRL_ADDR  = '0,
    parameter logic [ADDR_W-1:0] KEY_ADDR   = 1,
    parameter logic [7:0]        UNLOCK_KEY = 8'h96
) (
    input  logic              clk,
    input  logic              rst,
    input  logic [ADDR_W-1:0] bus_addr,
    input  logic              bus_we,
    input  logic [7:0]        bus_wdata,
    output logic [7:0]        bus_rdata,
    output logic [1:0]        sys_div_code,
    output logic [3:0]        sys_div_factor,
    output logic              presc_run,
    output logic              cpu_clk_fast,
    output logic              hs_osc_en,
    output logic              ls_osc_en,
    output logic              ctrl_unlocked
);
    logic              ctrl_sel, key_sel, ctrl_we, key_we;
    logic [BYTE_W-1:0] key_q;
    ctrl_t             ctrl_q;

    clkctl_keyreg_dec #(
        .ADDR_W    (ADDR_W),
        .CTRL_ADDR (CTRL_ADDR),
        .KEY_ADDR  (KEY_ADDR)
    ) u_dec (
        .addr     (bus_addr),
        .we       (bus_we),
        .ctrl_sel (ctrl_sel),
        .key_sel  (key_sel),
        .ctrl_we  (ctrl_we),
        .key_we   (key_we)
    );

    clkctl_keyreg_lock #(
        .UNLOCK_KEY (UNLOCK_KEY)
    ) u_lock (
        .clk      (clk),
        .rst      (rst),
        .key_we   (key_we),
        .wdata    (bus_wdata),
        .key_q    (key_q),
        .unlocked (ctrl_unlocked)
    );

    clkctl_keyreg_ctrl u_ctrl (
        .clk      (clk),
        .rst      (rst),
        .ctrl_we  (ctrl_we),
        .unlocked (ctrl_unlocked),
        .wdata    (bus_wdata),
        .ctrl_q   (ctrl_q)
    );

    always_comb begin
        if (ctrl_sel) begin
            bus_rdata = ctrl_to_byte(ctrl_q);
        end else if (key_sel) begin
            bus_rdata = key_q;
        end else begin
            bus_rdata = '0;
        end
    end

    assign sys_div_code   = ctrl_q.div;
    assign sys_div_factor = div_factor(ctrl_q.div);
    assign presc_run      = ctrl_q.run;
    assign cpu_clk_fast   = ctrl_q.fast;
    assign hs_osc_en      = ctrl_q.hs;
    assign ls_osc_en      = ctrl_q.ls;
endmodule

// File: rtl/clkctl_keyreg_chk.sv
module clkctl_keyreg_chk #(
    parameter int                ADDR_W     = 4,
    parameter logic [ADDR_W-1:0] CTRL_ADDR  = '0,
    parameter logic [ADDR_W-1:0] KEY_ADDR   = 1,
    parameter logic [7:0]        UNLOCK_KEY = 8'h96
) (
    input logic              clk,
    input logic              rst,
    input logic [ADDR_W-1:0] bus_addr,
    input logic              bus_we,
    input logic [7:0]        bus_wdata,
    input logic [7:0]        bus_rdata,
    input logic [1:0]        sys_div_code,
    input logic [3:0]        sys_div_factor,
    input logic              presc_run,
    input logic              cpu_clk_fast,
    input logic              hs_osc_en,
    input logic              ls_osc_en,
    input logic              ctrl_unlocked
);
    logic [6:0] outs;
    assign outs = {sys_div_code, presc_run, cpu_clk_fast, hs_osc_en, ls_osc_en, ctrl_unlocked};

    p_key_unlock_r2: assert property (@(posedge clk) disable iff (rst)
        (bus_we && bus_addr == KEY_ADDR && bus_wdata == UNLOCK_KEY) |=> ctrl_unlocked);

    p_key_relock_r3: assert property (@(posedge clk) disable iff (rst)
        (bus_we && bus_addr == KEY_ADDR && bus_wdata != UNLOCK_KEY) |=> !ctrl_unlocked);

    p_locked_hold_r4: assert property (@(posedge clk) disable iff (rst)
        (bus_we && bus_addr == CTRL_ADDR && !ctrl_unlocked) |=> $stable(outs));

    p_unlock_persist_r5: assert property (@(posedge clk) disable iff (rst)
        (ctrl_unlocked && !(bus_we && bus_addr == KEY_ADDR)) |=> ctrl_unlocked);

    p_reserved_zero_r6: assert property (@(posedge clk) disable iff (rst)
        (bus_addr == CTRL_ADDR) |-> (bus_rdata[4:3] == 2'b00));

    p_factor_onehot_r7: assert property (@(posedge clk) disable iff (rst)
        $countones(sys_div_factor) == 1);

    p_sel_hs_on_r9: assert property (@(posedge clk) disable iff (rst)
        cpu_clk_fast |-> hs_osc_en);

    p_sel_ls_on_r9: assert property (@(posedge clk) disable iff (rst)
        !cpu_clk_fast |-> ls_osc_en);

    p_stray_write_r10: assert property (@(posedge clk) disable iff (rst)
        (bus_we && bus_addr != CTRL_ADDR && bus_addr != KEY_ADDR) |=> $stable(outs));
endmodule

bind clkctl_keyreg clkctl_keyreg_chk #(
    .ADDR_W     (ADDR_W),
    .CTRL_ADDR  (CTRL_ADDR),
    .KEY_ADDR   (KEY_ADDR),
    .UNLOCK_KEY (UNLOCK_KEY)
) u_chk (
    .clk            (clk),
    .rst            (rst),
    .bus_addr       (bus_addr),
    .bus_we         (bus_we),
    .bus_wdata      (bus_wdata),
    .bus_rdata      (bus_rdata),
    .sys_div_code   (sys_div_code),
    .sys_div_factor (sys_div_factor),
    .presc_run      (presc_run),
    .cpu_clk_fast   (cpu_clk_fast),
    .hs_osc_en      (hs_osc_en),
    .ls_osc_en      (ls_osc_en),
    .ctrl_unlocked  (ctrl_unlocked)
);

// File: tb/test_clkctl_keyreg.sv
module test_clkctl_keyreg;
    localparam int CLK_PERIOD = 10;
    localparam logic [3:0] A_CTRL = 4'd0;
    localparam logic [3:0] A_KEY  = 4'd1;

    logic       clk = 1'b0;
    logic       rst = 1'b1;
    logic [3:0] bus_addr = '0;
    logic       bus_we = 1'b0;
    logic [7:0] bus_wdata = '0;
    logic [7:0] bus_rdata;
    logic [1:0] sys_div_code;
    logic [3:0] sys_div_factor;
    logic       presc_run, cpu_clk_fast, hs_osc_en, ls_osc_en, ctrl_unlocked;

    int checks = 0;
    int errors = 0;
    bit done = 0;

    // bench model
    logic [7:0] m_key;
    logic [1:0] m_div;
    logic       m_run, m_fast, m_hs, m_ls;

    clkctl_keyreg i_clkctl_keyreg (
        .clk(clk), .rst(rst), .bus_addr(bus_addr), .bus_we(bus_we),
        .bus_wdata(bus_wdata), .bus_rdata(bus_rdata),
        .sys_div_code(sys_div_code), .sys_div_factor(sys_div_factor),
        .presc_run(presc_run), .cpu_clk_fast(cpu_clk_fast),
        .hs_osc_en(hs_osc_en), .ls_osc_en(ls_osc_en),
        .ctrl_unlocked(ctrl_unlocked)
    );

    always #(CLK_PERIOD/2) clk = ~clk;

    function automatic logic [7:0] exp_ctrl_byte();
        return {m_div, m_run, 2'b00, m_fast, m_hs, m_ls};
    endfunction

    function automatic logic [3:0] exp_factor(input logic [1:0] c);
        case (c)
            2'd0: return 4'd1;
            2'd1: return 4'd2;
            2'd2: return 4'd4;
            default: return 4'd8;
        endcase
    endfunction

    task automatic chk(input bit ok, input string req, input logic [31:0] act, input logic [31:0] exp);
        checks++;
        if (!ok) begin
            errors++;
            $display("FAIL %s actual=%0h expected=%0h", req, act, exp);
        end
    endtask

    task automatic model_write(input logic [3:0] a, input logic [7:0] d);
        logic nhs, nls, tgt;
        if (a == A_KEY) begin
            m_key = d;
        end else if (a == A_CTRL && m_key == 8'h96) begin
            m_div = d[7:6];
            m_run = d[5];
            nhs = m_fast ? 1'b1 : d[1];
            nls = m_fast ? d[0] : 1'b1;
            tgt = d[2] ? nhs : nls;
            m_hs = nhs;
            m_ls = nls;
            if (tgt) m_fast = d[2];
        end
    endtask

    task automatic check_state(input string req);
        logic [6:0] act, exp;
        act = {sys_div_code, presc_run, cpu_clk_fast, hs_osc_en, ls_osc_en, ctrl_unlocked};
        exp = {m_div, m_run, m_fast, m_hs, m_ls, (m_key == 8'h96)};
        chk(act == exp, req, act, exp);
        chk(sys_div_factor == exp_factor(m_div), "R7 factor", sys_div_factor, exp_factor(m_div));
        bus_addr = A_CTRL;
        #1;
        chk(bus_rdata == exp_ctrl_byte(), {req, " ctrl read R6"}, bus_rdata, exp_ctrl_byte());
        bus_addr = A_KEY;
        #1;
        chk(bus_rdata == m_key, {req, " key read R10"}, bus_rdata, m_key);
    endtask

    task automatic wr(input logic [3:0] a, input logic [7:0] d, input string req);
        @(negedge clk);
        bus_addr  = a;
        bus_wdata = d;
        bus_we    = 1'b1;
        @(posedge clk);
        #1;
        bus_we = 1'b0;
        model_write(a, d);
        check_state(req);
    endtask

    initial begin
        #(CLK_PERIOD * 200000);
        if (!done) begin
            errors++;
            $display("FAIL watchdog expired");
            $display("  CHECKS %0d ERRORS %0d", checks, errors);
            $finish;
        end
    end

    initial begin
        void'($urandom(32'd2024));
        m_key = 8'h00; m_div = 2'd0; m_run = 1'b1; m_fast = 1'b1; m_hs = 1'b1; m_ls = 1'b1;
        repeat (3) @(posedge clk);
        @(negedge clk);
        rst = 1'b0;
        #1;
        check_state("R1 reset");

        wr(A_CTRL, 8'h40, "R4 locked write");
        wr(A_KEY, 8'h97, "R3 near key");
        wr(A_KEY, 8'h16, "R3 near key");
        wr(A_CTRL, 8'hC3, "R4 locked write");
        wr(A_KEY, 8'h96, "R2 unlock");
        wr(A_CTRL, 8'h47, "R2 first write");
        wr(A_CTRL, 8'hBF, "R5 second write, R6 reserved ones");
        for (int c = 0; c < 4; c++) wr(A_CTRL, {c[1:0], 6'b100111}, "R7 div code");
        wr(A_CTRL, 8'h25, "R8 clear running hs");
        wr(A_CTRL, 8'h26, "R8 clear ls while fast");
        wr(A_CTRL, 8'h22, "R9 switch to off ls");
        wr(A_CTRL, 8'h23, "R9 ls on then switch");
        wr(A_CTRL, 8'h21, "R9 switch to low");
        wr(A_CTRL, 8'h20, "R8 clear running ls");
        wr(A_CTRL, 8'h24, "R9 switch to off hs");
        wr(A_CTRL, 8'h26, "R9 hs on and switch");
        wr(4'd5, 8'h96, "R10 stray write");
        wr(4'd15, 8'h00, "R10 stray write");
        bus_addr = 4'd7;
        #1;
        chk(bus_rdata == 8'h00, "R10 stray read", bus_rdata, 8'h00);
        wr(A_KEY, 8'h00, "R3 relock");
        wr(A_CTRL, 8'h81, "R3 write after relock");

        for (int i = 0; i < 400; i++) begin
            int r;
            logic [3:0] a;
            logic [7:0] d;
            r = $urandom_range(0, 99);
            d = 8'($urandom);
            if (r < 45) a = A_CTRL;
            else if (r < 80) begin
                a = A_KEY;
                if (r < 65) d = 8'h96;
            end else a = 4'($urandom_range(2, 15));
            wr(a, d, "R5 random traffic");
        end

        done = 1;
        $display("  CHECKS %0d ERRORS %0d", checks, errors);
        $finish;
    end
endmodule